// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers the event pulses of a network controller's receive path, transmit path, block-transfer engine and error-tally logic into one status register. It pairs that register with a mask register of the same layout and drives a single level interrupt towards the host CPU. Each event arrives as a one-cycle pulse on its own input line and sets a sticky status bit. The CPU reads the status register to find out which events caused the interrupt. It then writes ones to the bits it has serviced, which clears them.

The top bit of the status register does not record an event. It reports whether the controller is halted or whether its receive ring has overflowed. It comes out of reset set, it is set by a stop command and cleared by a start command, and it also stays high for as long as the ring overflow flag is high. Writes cannot change it and it never raises the interrupt. Register access uses a plain port: an address, a write strobe, write data, and read data that follows the address combinationally.

Top module: `irq_ctl_top`

## Requirements
- R1: Event input k (0 packet received, 1 packet sent, 2 receive error, 3 send error, 4 ring space warning, 5 tally overflow, 6 transfer done) sets status bit k. The bit reads as 1 from the clock edge that samples the pulse onward.
- R2: A write to the status address (default 0x7) clears each status bit 0..6 whose write-data bit is 1. Bits written with 0 keep their value.
- R3: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R4: The interrupt output is 1 exactly while some status bit 0..6 is 1 and its mask bit is 1. It drops only after every such bit has been cleared or masked.
- R5: Status bit 7 is 1 after reset. A stop pulse sets it and a start pulse clears it. When both pulses come in the same cycle, stop takes priority.
- R6: Status bit 7 also reads 1 from the edge after the ring overflow input is sampled high, and for as long as that input stays high.
- R7: Writes to status bit 7 have no effect, and bit 7 never asserts the interrupt output.
- R8: The mask register resets to 0. A write to the mask address (default 0xF) loads bits 0..6 from write data. Mask bit 7 is reserved and always reads 0.
- R9: Reads have no side effects. Any address other than the status or mask address reads 0.
- R10: Status bits 0..6 reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_pulse | input | 7 | One-cycle event pulses, one per status bit 0..6 |
| stop_cmd | input | 1 | Pulse: controller enters its halted state |
| start_cmd | input | 1 | Pulse: controller is started |
| ring_ovf | input | 1 | Level: receive ring is in overflow |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Level interrupt request |

## Verification
Event pulses, writes, stop and start commands and the overflow level each pass through a single register. Their effect on the status and mask bits is therefore visible right after the next rising edge. The interrupt output is combinational on those registers, so it changes in the same cycle. Read data follows the address with no clock in between. The bench drives each stimulus at a falling edge and waits for the rising edge. It then parks the write strobe and the event lines and steps the address through the status and mask registers, checking read data and the interrupt a fraction of a nanosecond after each address change. All of this happens before the next falling edge, so every check samples one edge after its stimulus.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

   // Event source positions inside the status register
   typedef enum int {
      EV_PKT_RX    = 0,
      EV_PKT_TX    = 1,
      EV_RX_ERR    = 2,
      EV_TX_ERR    = 3,
      EV_RING_WARN = 4,
      EV_TALLY_OVF = 5,
      EV_XFER_DONE = 6
   } ev_idx_e;

   localparam int IRQ_EV_DEFAULT  = 7;
   localparam int IRQ_ADDR_W_DEF  = 4;

   // Sticky bit update: a new event beats a clear in the same cycle
   function automatic logic w1c_next(input logic cur, input logic set, input logic clr);
      return set | (cur & ~clr);
   endfunction

   // Halt flag update: stop beats start in the same cycle
   function automatic logic halt_next(input logic cur, input logic stop, input logic start);
      return stop | (cur & ~start);
   endfunction

endpackage

// File: rtl/irq_w1c_cell.sv
module irq_w1c_cell
   import irq_ctl_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);

   logic q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= 1'b0;
      else        q_r <= w1c_next(q_r, set_i, clr_i);
   end

   assign q_o = q_r;

endmodule

// File: rtl/irq_halt_cell.sv
module irq_halt_cell
   import irq_ctl_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic stop_i,
   input  logic start_i,
   input  logic ovf_i,
   output logic q_o
);

   logic halt_r;
   logic ovf_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_r <= 1'b1;
         ovf_r  <= 1'b0;
      end else begin
         halt_r <= halt_next(halt_r, stop_i, start_i);
         ovf_r  <= ovf_i;
      end
   end

   assign q_o = halt_r | ovf_r;

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int          WIDTH   = 7,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_r <= RST_VAL;
      else if (we_i) q_r <= d_i;
   end

   assign q_o = q_r;

endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
   import irq_ctl_pkg::*;
#(
   parameter int                N_EV      = IRQ_EV_DEFAULT,
   parameter int                ADDR_W    = IRQ_ADDR_W_DEF,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 4'h7,
   parameter logic [ADDR_W-1:0] MASK_ADDR = 4'hF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_EV-1:0]   ev_pulse,
   input  logic              stop_cmd,
   input  logic              start_cmd,
   input  logic              ring_ovf,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [N_EV:0]     wdata,
   output logic [N_EV:0]     rdata,
   output logic              irq
);

   localparam int REG_W    = N_EV + 1;
   localparam int HALT_BIT = N_EV;

   // Elaboration-time parameter checks
   if (N_EV < 1 || N_EV > 31) begin : g_bad_nev
      $error("irq_ctl_top: N_EV must lie in 1..31");
   end
   if (ADDR_W < 1) begin : g_bad_aw
      $error("irq_ctl_top: ADDR_W must be at least 1");
   end
   if (STAT_ADDR == MASK_ADDR) begin : g_bad_map
      $error("irq_ctl_top: status and mask addresses must differ");
   end

   logic              stat_wr_hit;
   logic              mask_wr_hit;
   logic [N_EV-1:0]   ev_bits;
   logic              halt_bit;
   logic [REG_W-1:0]  stat_vec;
   logic [N_EV-1:0]   mask_vec;
   logic              wdata_top_unused;

   assign stat_wr_hit      = wr_en && (addr == STAT_ADDR);
   assign mask_wr_hit      = wr_en && (addr == MASK_ADDR);
   assign wdata_top_unused = wdata[HALT_BIT];

   // One sticky write-one-to-clear cell per event source
   for (genvar i = 0; i < N_EV; i++) begin : g_ev
      irq_w1c_cell u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (ev_pulse[i]),
         .clr_i (stat_wr_hit & wdata[i]),
         .q_o   (ev_bits[i])
      );
   end

   // Halt / overflow indicator, not writable
   irq_halt_cell u_halt (
      .clk     (clk),
      .rst_n   (rst_n),
      .stop_i  (stop_cmd),
      .start_i (start_cmd),
      .ovf_i   (ring_ovf),
      .q_o     (halt_bit)
   );

   irq_mask_reg #(
      .WIDTH   (N_EV),
      .RST_VAL ('0)
   ) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (mask_wr_hit),
      .d_i   (wdata[N_EV-1:0]),
      .q_o   (mask_vec)
   );

   assign stat_vec = {halt_bit, ev_bits};

   // Only event bits take part in the request
   assign irq = |(ev_bits & mask_vec);

   always_comb begin
      if (addr == STAT_ADDR)      rdata = stat_vec;
      else if (addr == MASK_ADDR) rdata = {1'b0, mask_vec};
      else                        rdata = '0;
   end

endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk #(
   parameter int N_EV = 7
) (
   input logic            clk,
   input logic            rst_n,
   input logic [N_EV-1:0] ev_pulse,
   input logic            stop_cmd,
   input logic            start_cmd,
   input logic            ring_ovf,
   input logic            stat_wr_hit,
   input logic            mask_wr_hit,
   input logic [N_EV:0]   wdata,
   input logic [N_EV:0]   stat_vec,
   input logic [N_EV-1:0] mask_vec,
   input logic            irq
);

   assert_evt_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (|ev_pulse) |=> ((stat_vec[N_EV-1:0] & $past(ev_pulse)) == $past(ev_pulse)));

   assert_w1c_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr_hit && ev_pulse == '0) |=> ((stat_vec[N_EV-1:0] & $past(wdata[N_EV-1:0])) == '0));

   assert_w0_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr_hit |=> ((stat_vec[N_EV-1:0] & $past(stat_vec[N_EV-1:0] & ~wdata[N_EV-1:0]))
                       == $past(stat_vec[N_EV-1:0] & ~wdata[N_EV-1:0])));

   assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr_hit && (|(ev_pulse & wdata[N_EV-1:0])))
      |=> ((stat_vec[N_EV-1:0] & $past(ev_pulse & wdata[N_EV-1:0])) == $past(ev_pulse & wdata[N_EV-1:0])));

   assert_irq_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(ev_pulse) != '0 || $past(mask_wr_hit)));

   assert_stop_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      stop_cmd |=> stat_vec[N_EV]);

   assert_start_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (start_cmd && !stop_cmd && !ring_ovf) |=> !stat_vec[N_EV]);

   assert_ovf_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ring_ovf |=> stat_vec[N_EV]);

   assert_halt_no_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_vec[N_EV-1:0] & mask_vec) == '0) |-> !irq);

   assert_mask_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr_hit |=> (mask_vec == $past(wdata[N_EV-1:0])));

   assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_wr_hit |=> $stable(mask_vec));

endmodule

bind irq_ctl_top irq_ctl_chk #(.N_EV(N_EV)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ev_pulse    (ev_pulse),
   .stop_cmd    (stop_cmd),
   .start_cmd   (start_cmd),
   .ring_ovf    (ring_ovf),
   .stat_wr_hit (stat_wr_hit),
   .mask_wr_hit (mask_wr_hit),
   .wdata       (wdata),
   .stat_vec    (stat_vec),
   .mask_vec    (mask_vec),
   .irq         (irq)
);

// File: tb/irq_ctl_top_tb.sv
`timescale 1ns/100ps
module irq_ctl_top_tb;

   localparam logic [3:0] A_STAT = 4'h7;
   localparam logic [3:0] A_MASK = 4'hF;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] ev_pulse = '0;
   logic       stop_cmd = 1'b0;
   logic       start_cmd = 1'b0;
   logic       ring_ovf = 1'b0;
   logic [3:0] addr = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // Bench model state
   logic [6:0] m_ev;
   logic       m_halt;
   logic       m_ovf;
   logic [6:0] m_mask;

   always #2 clk = ~clk;

   irq_ctl_top u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_pulse  (ev_pulse),
      .stop_cmd  (stop_cmd),
      .start_cmd (start_cmd),
      .ring_ovf  (ring_ovf),
      .addr      (addr),
      .wr_en     (wr_en),
      .wdata     (wdata),
      .rdata     (rdata),
      .irq       (irq)
   );

   function automatic logic [7:0] exp_stat();
      return {m_halt | m_ovf, m_ev};
   endfunction

   function automatic logic exp_irq();
      return |(m_ev & m_mask);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Read back status, mask and interrupt with all strobes parked
   task automatic observe(input string tag);
      wr_en = 1'b0; ev_pulse = '0; stop_cmd = 1'b0; start_cmd = 1'b0;
      addr = A_STAT; #0.2;
      chk(tag, rdata, exp_stat());
      addr = A_MASK; #0.2;
      chk("R8 mask readback", rdata, {1'b0, m_mask});
      chk("R4 irq level", irq, exp_irq());
   endtask

   // One clock of stimulus, model update, then checks
   task automatic cyc(input string tag, input logic [6:0] ev, input logic wr, input logic [3:0] a,
                      input logic [7:0] wd, input logic stp, input logic sta, input logic ovf);
      @(negedge clk);
      ev_pulse = ev; wr_en = wr; addr = a; wdata = wd;
      stop_cmd = stp; start_cmd = sta; ring_ovf = ovf;
      @(posedge clk);
      m_ev   = ev | (m_ev & ~((wr && a == A_STAT) ? wd[6:0] : 7'h00));
      m_halt = stp | (m_halt & ~sta);
      m_ovf  = ovf;
      if (wr && a == A_MASK) m_mask = wd[6:0];
      #0.2;
      observe(tag);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240607));
      m_ev = '0; m_halt = 1'b1; m_ovf = 1'b0; m_mask = '0;
      #5;
      observe("R10 R5 reset state");
      chk("R5 reset halt bit", rdata[7], 1'b0);  // rdata now shows mask, bit 7 reserved
      addr = A_STAT; #0.2;
      chk("R5 reset status 0x80", rdata, 8'h80);
      @(negedge clk); rst_n = 1'b1;

      // R7: writing bit 7 does nothing, R5: start clears it
      cyc("R7 write halt bit", 7'h00, 1'b1, A_STAT, 8'hFF, 1'b0, 1'b0, 1'b0);
      chk("R7 halt bit kept", exp_stat(), 8'h80);
      cyc("R5 start clears", 7'h00, 1'b0, A_STAT, 8'h00, 1'b0, 1'b1, 1'b0);
      cyc("R5 stop beats start", 7'h00, 1'b0, A_STAT, 8'h00, 1'b1, 1'b1, 1'b0);
      cyc("R5 start again", 7'h00, 1'b0, A_STAT, 8'h00, 1'b0, 1'b1, 1'b0);

      // R1: each event sets its own bit, no irq while masked
      for (int k = 0; k < 7; k++)
         cyc("R1 single event", 7'(1 << k), 1'b0, A_STAT, 8'h00, 1'b0, 1'b0, 1'b0);
      chk("R1 all events seen", exp_stat(), 8'h7F);
      chk("R8 masked no irq", irq, 1'b0);

      // R8: mask bit 7 reserved; R4: transfer-done irq via mask bit 6
      cyc("R8 mask write", 7'h00, 1'b1, A_MASK, 8'hC0, 1'b0, 1'b0, 1'b0);
      chk("R4 irq from bit 6", irq, 1'b1);

      // R2: clear only written ones
      cyc("R2 partial clear", 7'h00, 1'b1, A_STAT, 8'h0F, 1'b0, 1'b0, 1'b0);
      chk("R2 upper bits kept", exp_stat(), 8'h70);
      // R3: set beats clear on bit 6
      cyc("R3 set wins", 7'h40, 1'b1, A_STAT, 8'h7F, 1'b0, 1'b0, 1'b0);
      chk("R3 bit 6 set", exp_stat(), 8'h40);
      chk("R4 irq still on", irq, 1'b1);
      cyc("R4 clear last source", 7'h00, 1'b1, A_STAT, 8'h40, 1'b0, 1'b0, 1'b0);
      chk("R4 irq dropped", irq, 1'b0);

      // R6 overflow level, R7 halt bit gives no irq even fully unmasked
      cyc("R8 unmask all", 7'h00, 1'b1, A_MASK, 8'hFF, 1'b0, 1'b0, 1'b0);
      cyc("R6 ovf raise", 7'h00, 1'b0, A_STAT, 8'h00, 1'b0, 1'b0, 1'b1);
      chk("R6 ovf bit", exp_stat(), 8'h80);
      chk("R7 halt no irq", irq, 1'b0);
      cyc("R6 ovf drop", 7'h00, 1'b0, A_STAT, 8'h00, 1'b0, 1'b0, 1'b0);

      // R9: unmapped read and repeated reads
      cyc("R9 prep", 7'h05, 1'b0, A_STAT, 8'h00, 1'b0, 1'b0, 1'b0);
      addr = 4'h3; #0.2;
      chk("R9 unmapped reads 0", rdata, 8'h00);
      addr = A_STAT; #0.2;
      chk("R9 first read", rdata, 8'h05);
      #0.2;
      chk("R9 second read", rdata, 8'h05);
      cyc("R9 no clear by read", 7'h00, 1'b0, A_STAT, 8'h00, 1'b0, 1'b0, 1'b0);

      // Constrained random traffic
      for (int n = 0; n < 3000; n++) begin
         logic [6:0] ev;
         logic       wr;
         logic [3:0] a;
         logic [7:0] wd;
         int         r;
         r  = $urandom_range(0, 9);
         ev = ($urandom_range(0, 3) == 0) ? 7'($urandom) : 7'h00;
         wr = ($urandom_range(0, 2) == 0);
         a  = (r < 5) ? A_STAT : (r < 8) ? A_MASK : 4'($urandom);
         wd = 8'($urandom);
         cyc("R2 random", ev, wr, a, wd,
             ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0),
             ($urandom_range(0, 7) == 0));
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule